// File: doc/BRIEF.md
# Six-Pin General Purpose I/O Controller with Level Interrupts

This block runs six general purpose pins from a small word-addressed register port. Each pin is set by software to be an input, a push-pull output or an open-drain output. Its output enable and output value go to a pad, and its input comes back through a two-flop synchronizer. That synchronized level is used both for data readback and for interrupt detection.

Each pin latches an interrupt status bit while its synchronized level matches a per-pin polarity. A status bit is cleared by writing 1 to it. Status bits that are enabled are ORed into one registered interrupt request. A mask captured at reset hands any subset of the pins to external LED status signals. Those pins are always driven push-pull, whatever their GPIO setup says.

Top module: `gpio_ctl`

## Requirements
- R1: While and after reset, every pin that is not LED-selected is an input with `pad_oe` low. The configuration word reads 0, the enables read 0, and `irq` is low. A polarity of 0 means a pin triggers on a low level.
- R2: The pin's data bit reads back the pad level through two flops. A change of `pad_in` made between clock edges shows in the data word after the second following rising edge and not after the first.
- R3: A pin in push-pull output mode drives `pad_oe`=1, and `pad_out` equals its data bit. Push-pull output is direction bit = 1 and buffer bit = 1.
- R4: A pin in open-drain output mode drives `pad_oe`=1 with `pad_out`=0 when its data bit is 0. It drives `pad_oe`=0 when its data bit is 1. Open-drain output is direction bit = 1 and buffer bit = 0.
- R5: In the data word, a pin whose direction bit is 1 reads back the value last written to it.
- R6: A status bit is set on the clock edge after the synchronized level equals the pin's polarity bit. A polarity bit of 1 means a high level.
- R7: Writing 1 to a status bit clears it. A 0 leaves it unchanged. If the matching level is still present on that edge, the bit stays set.
- R8: `irq` is registered. It goes high one clock after any status bit with its enable set becomes set. It stays low when no enabled status bit is set.
- R9: `led_mask` is captured while `rst_n` is low and is ignored afterwards. A masked pin drives `pad_oe`=1 and `pad_out`=`led_sig` for that pin, whatever its direction, buffer or data bits hold.
- R10: The register map is as follows. Address 0 holds direction in [5:0], buffer type in [13:8] and polarity in [21:16]. Address 1 holds data in [5:0]. Address 2 holds status in [5:0] and enable in [21:16]. Unused bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| led_mask | input | 6 | Pins handed to LED signals, captured in reset |
| led_sig | input | 6 | LED status levels |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output value |
| pad_oe | output | 6 | Pad output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong direction or buffer bit shows at once on `pad_oe` and `pad_out`, on the edge that writes it. A synchronizer with the wrong depth moves data readback by one cycle, which the directed latency check catches. A status bit with the wrong polarity or clear priority shows in the status word one edge after the level settles. It reaches `irq` one edge after that. A mask that is not held after reset shows on the LED pins as soon as `led_mask` changes.

// File: rtl/gpio_ctl.sv
module gpio_ctl #(
  parameter int N = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [N-1:0] led_mask,
  input  logic [N-1:0] led_sig,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic        irq
);
  localparam int BUF_LSB = 8;
  localparam int POL_LSB = 16;

  logic [N-1:0] dir_q, buf_q, pol_q, dat_q, sts_q, en_q, led_q;
  logic [N-1:0] meta_q, sync_q;
  logic [N-1:0] hit, clr, rd_dat;

  assign hit    = ~(sync_q ^ pol_q);
  assign clr    = (reg_we && reg_addr == 2'd2) ? reg_wdata[N-1:0] : '0;
  assign rd_dat = (dir_q & dat_q) | (~dir_q & sync_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      buf_q  <= '0;
      pol_q  <= '0;
      dat_q  <= '0;
      sts_q  <= '0;
      en_q   <= '0;
      meta_q <= '0;
      sync_q <= '0;
      led_q  <= led_mask;
      irq    <= 1'b0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      sts_q  <= hit | (sts_q & ~clr);
      irq    <= |(sts_q & en_q);
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            dir_q <= reg_wdata[N-1:0];
            buf_q <= reg_wdata[BUF_LSB +: N];
            pol_q <= reg_wdata[POL_LSB +: N];
          end
          2'd1: dat_q <= reg_wdata[N-1:0];
          2'd2: en_q  <= reg_wdata[POL_LSB +: N];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[N-1:0]          = dir_q;
        reg_rdata[BUF_LSB +: N]   = buf_q;
        reg_rdata[POL_LSB +: N]   = pol_q;
      end
      2'd1: reg_rdata[N-1:0] = rd_dat;
      2'd2: begin
        reg_rdata[N-1:0]        = sts_q;
        reg_rdata[POL_LSB +: N] = en_q;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_pad
    always_comb begin
      if (led_q[i]) begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = led_sig[i];
      end else if (!dir_q[i]) begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = 1'b0;
      end else if (buf_q[i]) begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = dat_q[i];
      end else begin
        pad_oe[i]  = ~dat_q[i];
        pad_out[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] dir_q,
  input logic [N-1:0] buf_q,
  input logic [N-1:0] pol_q,
  input logic [N-1:0] sync_q,
  input logic [N-1:0] sts_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] led_q,
  input logic [N-1:0] led_sig,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic         irq
);
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~led_q & ~dir_q) == '0); // R1
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & ~led_q & dir_q & ~buf_q) == '0); // R4
  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~($past(sync_q) ^ $past(pol_q))) & ~sts_q) == '0); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & en_q)) |=> irq); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_q & en_q)) |=> !irq); // R8
  AST_LED_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((led_q & ~pad_oe) == '0) && ((led_q & (pad_out ^ led_sig)) == '0)); // R9
  AST_LED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(led_q)); // R9
endmodule

bind gpio_ctl gpio_ctl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .buf_q(buf_q), .pol_q(pol_q),
  .sync_q(sync_q), .sts_q(sts_q), .en_q(en_q), .led_q(led_q),
  .led_sig(led_sig), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/sim_gpio_ctl.sv
`timescale 1ns/1ps
module sim_gpio_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  led_mask = 6'b100001;
  logic [5:0]  led_sig = '0;
  logic [5:0]  pad_in = '0;
  logic [5:0]  pad_out, pad_oe;
  logic        irq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  gpio_ctl u0 (.*);

  always #5 clk = ~clk;

  localparam logic [5:0] LED = 6'b100001;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [5:0] exp_oe(logic [5:0] dir, logic [5:0] bf, logic [5:0] dat);
    return LED | (~LED & dir & (bf | ~dat));
  endfunction

  function automatic logic [5:0] exp_drv(logic [5:0] dir, logic [5:0] bf, logic [5:0] dat, logic [5:0] ls);
    return (LED & ls) | (~LED & dir & bf & dat);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    led_mask = 6'b000000;
    #1;
    chk("R1 pad_oe after reset", {26'd0, pad_oe}, {26'd0, LED});
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(2'd0, r); chk("R1 config word", r, 32'd0);
    rd(2'd2, r); chk("R1 enable bits", r & 32'h003F0000, 32'd0);
    rd(2'd3, r); chk("R10 addr 3 reads 0", r, 32'd0);

    led_sig = 6'b100000;
    #1 chk("R9 LED pins follow led_sig", {26'd0, pad_out & LED}, {26'd0, 6'b100000});

    // R2 synchronizer latency
    pad_in = 6'b010101;
    repeat (4) @(negedge clk);
    pad_in = 6'b101010;
    @(posedge clk); #1;
    rd(2'd1, r); chk("R2 one edge: old value", r, 32'h15);
    @(posedge clk); #1;
    rd(2'd1, r); chk("R2 two edges: new value", r, 32'h2A);

    // R10 field positions
    wr(2'd0, 32'h002A_151E);
    rd(2'd0, r); chk("R10 config fields", r, 32'h002A_151E);

    // R8 latency with high polarity on all pins
    pad_in = 6'b000000;
    wr(2'd0, 32'h003F_0000);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h0001_003F);
    @(negedge clk); @(negedge clk);
    chk("R8 irq low with no enabled status", {31'd0, irq}, 32'd0);
    pad_in = 6'b000001;
    repeat (3) @(posedge clk); #1;
    rd(2'd2, r); chk("R6 status set on high level", r & 32'h3F, 32'h01);
    chk("R8 irq still low", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    chk("R8 irq one clock after status", {31'd0, irq}, 32'd1);

    // R7 level present wins over clear, then clear works
    wr(2'd2, 32'h0001_003F);
    rd(2'd2, r); chk("R7 set beats clear", r & 32'h3F, 32'h01);
    pad_in = 6'b000000;
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h0001_0000);
    rd(2'd2, r); chk("R7 write 0 keeps status", r & 32'h3F, 32'h01);
    wr(2'd2, 32'h0001_0001);
    rd(2'd2, r); chk("R7 write 1 clears", r & 32'h3F, 32'h00);
    @(negedge clk);
    chk("R8 irq drops after clear", {31'd0, irq}, 32'd0);

    for (int it = 0; it < 60; it++) begin
      logic [5:0] dir, bf, pol, dat, pin, en, ls;
      dir = 6'($urandom); bf = 6'($urandom); pol = 6'($urandom);
      dat = 6'($urandom); pin = 6'($urandom); en = 6'($urandom);
      ls = 6'($urandom);
      if (it < 4) begin
        dir = 6'h3F; bf = (it[0]) ? 6'h3F : 6'h00; dat = (it[1]) ? 6'h3F : 6'h00;
      end
      if (it == 10) led_mask = 6'h3F;
      led_sig = ls;
      wr(2'd0, {10'd0, pol, 2'd0, bf, 2'd0, dir});
      wr(2'd1, {26'd0, dat});
      pad_in = pin;
      repeat (3) @(negedge clk);
      #1;
      chk("R3/R4/R9 pad_oe", {26'd0, pad_oe}, {26'd0, exp_oe(dir, bf, dat)});
      chk("R3/R9 driven value", {26'd0, pad_out & pad_oe},
          {26'd0, exp_drv(dir, bf, dat, ls)});
      rd(2'd1, r);
      chk("R2/R5 data readback", r, {26'd0, (dir & dat) | (~dir & pin)});
      wr(2'd2, {10'd0, en, 10'd0, 6'h3F});
      rd(2'd2, r);
      chk("R6/R7 status after clear", r, {10'd0, en, 10'd0, ~(pin ^ pol)});
      @(negedge clk);
      chk("R8 irq from enabled status", {31'd0, irq}, {31'd0, |(~(pin ^ pol) & en)});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule